// File: doc/BRIEF.md
# Write-Protected Two-Level Pin Function Selector

This block is a register bank that stores the function choice and pad settings for every configurable I/O pin of a device, and turns them into a resolved function number per pin. Each pin owns one word in a first-level bank and one word in a second-level bank. The first-level word carries a 4-bit function code, a pull setting and a drive-strength setting. One code value is an escape: it hands the choice of function to the pin's second-level word. The second-level bank also holds two source selectors for the two management-data (MDIO) channels.

Both banks are guarded against stray writes. Each bank has a protect register at word index 0x100, and its key is that register's own system address. Writing the key with bit 0 set opens the bank. Writing the key with bit 0 clear closes it again. Software opens a bank, changes the pins it needs, and then closes the bank. Reads are never blocked.

The bus is a plain single-cycle port. A write takes effect on the clock edge at which `bus_we` is high. Read data is combinational from `bus_addr`. Address bit 12 selects the bank (0 is first level, 1 is second level). Bits [11:2] form the word index.

Top module: `pinmux_guard`

## Requirements
- R1: After reset both banks are closed and every pin and MDIO register holds 0. A protect register reads back its key address with bit 0 = 0. With the default high-Z code 0, every pin therefore reports function 0 and high-impedance.
- R2: A write to a bank's protect register is always accepted, whether the bank is open or closed. Its effect depends on the written data:
  - If bits [31:1] match that bank's key address, bit 0 = 1 opens the bank and bit 0 = 0 closes it.
  - If bits [31:1] do not match, the bank's state does not change.
  - Each bank's state is independent of the other's.
  - The register reads back the key address with bit 0 = 1 when open and 0 when closed.
- R3: While a bank is closed, writes to its pin words and MDIO registers are ignored. Read-back values and outputs stay unchanged.
- R4: The first-level pin word stores its fields as follows, and all other bits read as 0:
  - bits [3:0]: function code
  - bits [9:8]: pull setting (00 none, 01 pull-up, 11 pull-down), presented on `pin_pull`
  - bits [11:10]: drive strength (00 = 4 mA, 01 = 6 mA, 10 = 8 mA, 11 = 12 mA), presented on `pin_drive`
- R5: A first-level code from 0 to 9 resolves to that same function number on `pin_func`.
- R6: First-level code 0xF resolves to 10 plus the pin's second-level value. The second-level word stores bits [5:0] and reads back only those bits. Values 0 to 61 give function numbers 10 to 71.
- R7: `pin_hiz` is 1, and `pin_func` equals HIZ_CODE, when either of these holds:
  - the code equals HIZ_CODE;
  - the code is one of the reserved values 10 to 14.
- R8: With code 0xF, `pin_hiz` is 1 when the second-level value is 0, while `pin_func` reads 10. When the second-level value is 62 or 63, `pin_hiz` is 1 and `pin_func` equals HIZ_CODE.
- R9: The second-level bank holds the MDIO channel 0 source at word index 0x101 and the channel 1 source at index 0x102. Each is 3 bits (0 is high-impedance, 1 to 7 are internal sources). Channel 0 appears on `mdio_src[2:0]` and channel 1 on `mdio_src[5:3]`.
- R10: Reads from unmapped word indices return 0, and writes to them change nothing. This includes indices 0x101 and 0x102 in the first-level bank.
- R11: Pin n sits at word index n in both banks. The last pin, NUM_PINS-1, is fully addressable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 13 | Byte address; bit 12 selects the bank, bits [11:2] the word |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| pin_func | output | NUM_PINS*7 | Resolved function number, 7 bits per pin |
| pin_hiz | output | NUM_PINS | Pin is in the high-impedance function |
| pin_pull | output | NUM_PINS*2 | Pull setting per pin |
| pin_drive | output | NUM_PINS*2 | Drive-strength code per pin |
| mdio_src | output | 6 | MDIO source selects, channel 0 in [2:0] |

## Verification
The assertions assume the following about the bus inputs:
- `bus_we`, `bus_addr` and `bus_wdata` are stable around each rising edge.
- Accesses are word aligned, so bits [1:0] of the address are ignored.

The bench meets this by changing every bus input only on falling edges, and by using only word-aligned addresses. The freeze checks on closed banks assume that no reset pulse occurs during a run. The bench applies reset once, at the start.

// File: rtl/pinmux_guard.sv
module pinmux_guard #(
  parameter int          NUM_PINS    = 170,
  parameter logic [31:0] L1_KEY_ADDR = 32'h4006_2400,
  parameter logic [31:0] L2_KEY_ADDR = 32'h4006_3400,
  parameter int          HIZ_CODE    = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [12:0]           bus_addr,
  input  logic                  bus_we,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic [NUM_PINS*7-1:0] pin_func,
  output logic [NUM_PINS-1:0]   pin_hiz,
  output logic [NUM_PINS*2-1:0] pin_pull,
  output logic [NUM_PINS*2-1:0] pin_drive,
  output logic [5:0]            mdio_src
);
  localparam int         PIN_AW    = $clog2(NUM_PINS);
  localparam logic [9:0] KEY_IDX   = 10'h100;
  localparam logic [9:0] MDIO0_IDX = 10'h101;
  localparam logic [9:0] MDIO1_IDX = 10'h102;
  localparam logic [6:0] HIZ_FN    = 7'(HIZ_CODE);

  logic [3:0] code_q [NUM_PINS];
  logic [1:0] pull_q [NUM_PINS];
  logic [1:0] drv_q  [NUM_PINS];
  logic [5:0] sel2_q [NUM_PINS];
  logic [2:0] mdio_q [2];
  logic       open1, open2;

  wire             bank2   = bus_addr[12];
  wire [9:0]       widx    = bus_addr[11:2];
  wire [PIN_AW-1:0] pidx   = widx[PIN_AW-1:0];
  wire             pin_hit = widx < 10'(NUM_PINS);
  wire             key_hit = widx == KEY_IDX;
  wire             key_ok  = bus_wdata[31:1] ==
                             (bank2 ? L2_KEY_ADDR[31:1] : L1_KEY_ADDR[31:1]);

  wire wr_key1 = bus_we && !bank2 && key_hit && key_ok;
  wire wr_key2 = bus_we &&  bank2 && key_hit && key_ok;
  wire wr_pin1 = bus_we && !bank2 && pin_hit && open1;
  wire wr_pin2 = bus_we &&  bank2 && pin_hit && open2;
  wire wr_md0  = bus_we &&  bank2 && widx == MDIO0_IDX && open2;
  wire wr_md1  = bus_we &&  bank2 && widx == MDIO1_IDX && open2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open1 <= 1'b0;
      open2 <= 1'b0;
    end else begin
      if (wr_key1) open1 <= bus_wdata[0];
      if (wr_key2) open2 <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        code_q[i] <= '0;
        pull_q[i] <= '0;
        drv_q[i]  <= '0;
        sel2_q[i] <= '0;
      end
      mdio_q[0] <= '0;
      mdio_q[1] <= '0;
    end else begin
      if (wr_pin1) begin
        code_q[pidx] <= bus_wdata[3:0];
        pull_q[pidx] <= bus_wdata[9:8];
        drv_q[pidx]  <= bus_wdata[11:10];
      end
      if (wr_pin2) sel2_q[pidx] <= bus_wdata[5:0];
      if (wr_md0)  mdio_q[0]    <= bus_wdata[2:0];
      if (wr_md1)  mdio_q[1]    <= bus_wdata[2:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (!bank2) begin
      if (pin_hit)      bus_rdata = {20'b0, drv_q[pidx], pull_q[pidx], 4'b0, code_q[pidx]};
      else if (key_hit) bus_rdata = {L1_KEY_ADDR[31:1], open1};
    end else begin
      if (pin_hit)                 bus_rdata = {26'b0, sel2_q[pidx]};
      else if (key_hit)            bus_rdata = {L2_KEY_ADDR[31:1], open2};
      else if (widx == MDIO0_IDX)  bus_rdata = {29'b0, mdio_q[0]};
      else if (widx == MDIO1_IDX)  bus_rdata = {29'b0, mdio_q[1]};
    end
  end

  assign mdio_src = {mdio_q[1], mdio_q[0]};

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic [6:0] fn;
    logic       hz;
    always_comb begin
      if (code_q[g] <= 4'd9) begin
        fn = {3'b0, code_q[g]};
        hz = (code_q[g] == 4'(HIZ_CODE));
      end else if (code_q[g] == 4'hF && sel2_q[g] <= 6'd61) begin
        fn = 7'(sel2_q[g]) + 7'd10;
        hz = (sel2_q[g] == 6'd0);
      end else begin
        fn = HIZ_FN;
        hz = 1'b1;
      end
    end
    assign pin_func[g*7 +: 7]  = fn;
    assign pin_hiz[g]          = hz;
    assign pin_pull[g*2 +: 2]  = pull_q[g];
    assign pin_drive[g*2 +: 2] = drv_q[g];
  end
endmodule

// File: rtl/pinmux_guard_chk.sv
module pinmux_guard_chk #(
  parameter int NUM_PINS = 170
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [12:0]           bus_addr,
  input logic                  bus_we,
  input logic [31:0]           bus_rdata,
  input logic                  open1,
  input logic                  open2,
  input logic [NUM_PINS*7-1:0] pin_func,
  input logic [NUM_PINS*2-1:0] pin_pull,
  input logic [NUM_PINS*2-1:0] pin_drive,
  input logic [5:0]            mdio_src
);
  assert_closed_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!open1 && !open2));

  assert_lock_only_by_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr[11:2] == 10'h100) |=> ($stable(open1) && $stable(open2)));

  assert_l1_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !open1 |=> ($stable(pin_pull) && $stable(pin_drive)));

  assert_mdio_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !open2 |=> $stable(mdio_src));

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_addr[12] && bus_addr[11:2] >= 10'(NUM_PINS) && bus_addr[11:2] != 10'h100)
      |-> bus_rdata == 32'd0);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_rng
    assert_func_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pin_func[g*7 +: 7] <= 7'd71);
  end
endmodule

bind pinmux_guard pinmux_guard_chk #(.NUM_PINS(NUM_PINS)) chk_i (.*);

// File: tb/pinmux_guard_tb.sv
module pinmux_guard_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          NP   = 170;
  localparam logic [31:0] K1   = 32'h4006_2400;
  localparam logic [31:0] K2   = 32'h4006_3400;
  localparam int          NV   = 9;
  localparam logic [31:0] VL1 [NV] = '{32'h003, 32'h109, 32'hB0F, 32'hC0F, 32'h000,
                                       32'h00B, 32'h00F, 32'h00F, 32'hFFFF_F70F};
  localparam logic [31:0] VL2 [NV] = '{32'h0, 32'h0, 32'h1C, 32'h0, 32'h5,
                                       32'h0, 32'd61, 32'h3F, 32'hFFFF_FFC1};
  localparam logic [6:0]  EF  [NV] = '{7'd3, 7'd9, 7'd38, 7'd10, 7'd0, 7'd0, 7'd71, 7'd0, 7'd11};
  localparam logic        EH  [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [1:0]  EP  [NV] = '{2'd0, 2'd1, 2'd3, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd3};
  localparam logic [1:0]  ED  [NV] = '{2'd0, 2'd0, 2'd2, 2'd3, 2'd0, 2'd0, 2'd0, 2'd0, 2'd1};

  logic            clk = 0, rst_n = 0, bus_we = 0;
  logic [12:0]     bus_addr = '0;
  logic [31:0]     bus_wdata = '0, bus_rdata;
  logic [NP*7-1:0] pin_func;
  logic [NP-1:0]   pin_hiz;
  logic [NP*2-1:0] pin_pull, pin_drive;
  logic [5:0]      mdio_src;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinmux_guard #(.NUM_PINS(NP), .L1_KEY_ADDR(K1), .L2_KEY_ADDR(K2)) dut_i (.*);

  task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=0x%0h exp=0x%0h", what, got, exp);
    end
  endtask

  task automatic wr(logic [12:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0; #1;
  endtask

  task automatic rd(logic [12:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(13'h0400, r); chk("R1 l1 protect", r, {K1[31:1], 1'b0});
    rd(13'h1400, r); chk("R1 l2 protect", r, {K2[31:1], 1'b0});
    rd(13'h0014, r); chk("R1 pin word", r, 0);
    chk("R1 mdio", 32'(mdio_src), 0);
    chk("R1 all hiz", 32'(&pin_hiz), 1);
    chk("R1 func zero", 32'(|pin_func), 0);
    // R3 closed banks ignore writes
    wr(13'h001C, 32'h30F); rd(13'h001C, r); chk("R3 l1 locked readback", r, 0);
    chk("R3 l1 locked pull", 32'(pin_pull[7*2 +: 2]), 0);
    wr(13'h1404, 32'd5); chk("R3 mdio locked", 32'(mdio_src), 0);
    // R2 wrong key ignored
    wr(13'h0400, (K1 ^ 32'h100) | 32'h1); rd(13'h0400, r); chk("R2 bad key", r, {K1[31:1], 1'b0});
    wr(13'h0400, K2 | 32'h1); rd(13'h0400, r); chk("R2 other bank key", r, {K1[31:1], 1'b0});
    // R2 open bank 1 only
    wr(13'h0400, K1 | 32'h1); rd(13'h0400, r); chk("R2 open l1", r, K1 | 32'h1);
    rd(13'h1400, r); chk("R2 l2 still closed", r, {K2[31:1], 1'b0});
    wr(13'h1404, 32'd5); chk("R2 r3 mdio still locked", 32'(mdio_src), 0);
    wr(13'h001C, 32'h30F); chk("R4 pull pin7", 32'(pin_pull[7*2 +: 2]), 3);
    wr(13'h1400, K2 | 32'h1); rd(13'h1400, r); chk("R2 open l2", r, K2 | 32'h1);
    // Table: R4..R8 on pin 5
    for (int i = 0; i < NV; i++) begin
      wr(13'h0014, VL1[i]);
      wr(13'h1014, VL2[i]);
      chk($sformatf("R5 R6 R7 R8 func v%0d", i), 32'(pin_func[5*7 +: 7]), 32'(EF[i]));
      chk($sformatf("R7 R8 hiz v%0d", i), 32'(pin_hiz[5]), 32'(EH[i]));
      chk($sformatf("R4 pull v%0d", i), 32'(pin_pull[5*2 +: 2]), 32'(EP[i]));
      chk($sformatf("R4 drive v%0d", i), 32'(pin_drive[5*2 +: 2]), 32'(ED[i]));
      rd(13'h0014, r); chk($sformatf("R4 l1 readback v%0d", i), r, VL1[i] & 32'hF0F);
      rd(13'h1014, r); chk($sformatf("R6 l2 readback v%0d", i), r, VL2[i] & 32'h3F);
    end
    // R9 MDIO
    wr(13'h1404, 32'd5); wr(13'h1408, 32'hFFFF_FFFA);
    chk("R9 mdio outputs", 32'(mdio_src), 32'h15);
    rd(13'h1408, r); chk("R9 mdio1 readback", r, 2);
    // R11 last pin
    wr(13'h02A4, 32'h00F); wr(13'h12A4, 32'd61);
    chk("R11 last pin func", 32'(pin_func[169*7 +: 7]), 71);
    rd(13'h12A4, r); chk("R11 last pin l2 readback", r, 61);
    // R10 unmapped
    wr(13'h02A8, 32'hFFF); rd(13'h02A8, r); chk("R10 past last pin", r, 0);
    chk("R10 last pin untouched", 32'(pin_func[169*7 +: 7]), 71);
    wr(13'h0404, 32'h7); rd(13'h0404, r); chk("R10 l1 mdio slot", r, 0);
    wr(13'h140C, 32'h7); rd(13'h140C, r); chk("R10 l2 gap", r, 0);
    chk("R10 mdio untouched", 32'(mdio_src), 32'h15);
    // R2/R3 close bank 1 again, bank 2 stays open
    wr(13'h0400, K1); rd(13'h0400, r); chk("R2 close l1", r, {K1[31:1], 1'b0});
    wr(13'h0014, 32'h001); rd(13'h0014, r); chk("R3 relocked l1", r, 32'h70F);
    wr(13'h1014, 32'd2); chk("R6 l2 open after l1 closed", 32'(pin_func[5*7 +: 7]), 12);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule